// File: doc/BRIEF.md
# Comma-Aligning Deserializer

This block turns a retimed serial bit stream into parallel characters of ten bits, delivered either one or two at a time on a 20-bit bus. A bit-clock enable marks each received bit. The block places word boundaries so that the positive-disparity comma lands at the start of a word. A single-cycle word strobe marks every bus update, and a sync flag rises whenever a comma sits on the bus.

Framing can be switched off. The block then keeps whatever boundary it has and hands out whole words at a fixed rate. Moving the boundary never produces a word shorter than the nominal length: the word in progress is stretched instead. To make that possible, the bus runs one character behind the serial input, so a comma can always be delivered in the first character slot.

Top module: `comma_deser`

## Requirements
- R1: A comma is the 7-bit pattern 0011111 in the first seven received bits of a 10-bit character, with the last three bits free. The inverted pattern 1100000 is not a comma and never moves the boundary. On the bus, the first received bit of each character sits at the highest index of its half.
- R2: With framing enabled, a comma whose last pattern bit arrives on event c is followed by a strobe on bit event c+3+W, where W is 10 in narrow mode and 20 in wide mode. The character holding the comma is then on bus bits 19:10. An already aligned comma leaves the boundary in place.
- R3: In wide mode (wideMode=1), each strobe delivers two characters. The earlier character is on bits 19:10 and the later one on bits 9:0, and a realigned comma always lands in the earlier slot.
- R4: Two consecutive strobes are never fewer than W bit events apart, even when a comma forces realignment.
- R5: With framing disabled, no realignment happens and strobes follow every W bit events.
- R6: In narrow mode (wideMode=0), each strobe delivers one character on bits 19:10 with bits 9:0 all ones.
- R7: syncFlag is high exactly while the bus holds a comma in bits 19:13, or, in wide mode, in bits 9:3.
- R8: Synchronous reset (rst=1) clears the bus and the strobe and lowers syncFlag. After reset, the first strobe comes no earlier than bit event W+10, so every delivered bit was received after reset.
- R9: wordStb pulses for one clock, in the cycle after the bit event that completes a word. outBus and syncFlag change only together with that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bitEn | input | 1 | One received bit is valid this cycle |
| serIn | input | 1 | Received serial bit |
| wideMode | input | 1 | 1: two characters per word, 0: one character |
| frameEn | input | 1 | 1: align to commas, 0: unframed |
| outBus | output | 20 | Parallel word |
| wordStb | output | 1 | Word strobe, one cycle per bus update |
| syncFlag | output | 1 | Comma present on the bus |

## Verification
The hardest case to reach is a comma that ends just before or just after a pending boundary. A naive realignment would emit a runt word there, so the stretch logic has to take over. The stimulus reaches this case in two ways. It sends streams of characters broken by random slips of one to nine bits, with commas, inverted commas and random idle cycles between bit events. It also sends a directed sequence of slips of exactly one and nine bits right before commas. A bench model built on boundary targets predicts every strobe, bus value and flag, and the spacing of observed strobes is measured as well.

// File: rtl/deser_pkg.sv
package deser_pkg;
  typedef struct packed {
    logic shift;    // take one serial bit into the history
    logic capture;  // load the bus from the history
  } deserCtl_t;
endpackage

// File: rtl/deser_datapath.sv
module deser_datapath
  import deser_pkg::*;
#(
  parameter int CHAR_W = 10,
  parameter int PAT_W = 7,
  parameter logic [PAT_W-1:0] COMMA_PAT = 7'b0011111
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  serIn,
  input  logic                  wideMode,
  input  deserCtl_t             ctl,
  output logic                  rawComma,
  output logic [2*CHAR_W-1:0]   outBus,
  output logic                  syncFlag
);
  localparam int WORD_MAX = 2 * CHAR_W;
  localparam int HIST_W = 3 * CHAR_W;
  localparam int SLOTS = WORD_MAX / CHAR_W;

  logic [HIST_W-2:0]   hist;
  logic [HIST_W-1:0]   nextHist;
  logic [WORD_MAX-1:0] capWord;
  logic [SLOTS-1:0]    slotHit;
  logic                capSync;

  always_comb begin
    nextHist = {hist, serIn};
    // newest ten bits form a full character whose head is the pattern
    rawComma = nextHist[CHAR_W-1 -: PAT_W] == COMMA_PAT;
    // the bus trails the input by one character
    if (wideMode) capWord = nextHist[HIST_W-1:CHAR_W];
    else          capWord = {nextHist[WORD_MAX-1:CHAR_W], {CHAR_W{1'b1}}};
  end

  genvar s;
  generate
    for (s = 0; s < SLOTS; s++) begin : g_slot
      assign slotHit[s] = capWord[s*CHAR_W + CHAR_W-1 -: PAT_W] == COMMA_PAT;
    end
  endgenerate

  assign capSync = slotHit[SLOTS-1] | (wideMode & (|slotHit[SLOTS-2:0]));

  always_ff @(posedge clk) begin
    if (rst) begin
      hist     <= '0;
      outBus   <= '0;
      syncFlag <= 1'b0;
    end else begin
      if (ctl.shift) hist <= nextHist[HIST_W-2:0];
      if (ctl.capture) begin
        outBus   <= capWord;
        syncFlag <= capSync;
      end
    end
  end
endmodule

// File: rtl/deser_ctrl.sv
module deser_ctrl
  import deser_pkg::*;
#(
  parameter int CHAR_W = 10
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      bitEn,
  input  logic      frameEn,
  input  logic      wideMode,
  input  logic      rawComma,
  output deserCtl_t ctl,
  output logic      wordStb
);
  localparam int WORD_MAX = 2 * CHAR_W;
  localparam int HIST_W = 3 * CHAR_W;
  localparam int CNT_W = $clog2(HIST_W + 1);
  localparam logic [CNT_W-1:0] CHAR_L = CNT_W'(CHAR_W);
  localparam logic [CNT_W-1:0] WORD_L = CNT_W'(WORD_MAX);
  localparam logic [CNT_W-1:0] HIST_L = CNT_W'(HIST_W);
  localparam logic [CNT_W-1:0] ONE_L  = CNT_W'(1);

  logic [CNT_W-1:0] phaseCnt, seenCnt, seenNext, wordLen;
  logic due, primed, commaOk;

  always_comb begin
    wordLen  = wideMode ? WORD_L : CHAR_L;
    seenNext = (seenCnt == HIST_L) ? seenCnt : seenCnt + ONE_L;
    due      = phaseCnt >= wordLen - ONE_L;
    primed   = seenNext >= wordLen + CHAR_L;
    commaOk  = frameEn && rawComma && (seenNext >= CHAR_L);
    ctl.shift   = bitEn;
    ctl.capture = bitEn && due && primed;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseCnt <= '0;
      seenCnt  <= '0;
      wordStb  <= 1'b0;
    end else begin
      wordStb <= ctl.capture;
      if (bitEn) begin
        seenCnt <= seenNext;
        // a comma off the boundary restarts the word: the current one stretches
        if (due || commaOk) phaseCnt <= '0;
        else                phaseCnt <= phaseCnt + ONE_L;
      end
    end
  end
endmodule

// File: rtl/comma_deser.sv
module comma_deser
  import deser_pkg::*;
#(
  parameter int CHAR_W = 10,
  parameter int PAT_W = 7,
  parameter logic [PAT_W-1:0] COMMA_PAT = 7'b0011111
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bitEn,
  input  logic                serIn,
  input  logic                wideMode,
  input  logic                frameEn,
  output logic [2*CHAR_W-1:0] outBus,
  output logic                wordStb,
  output logic                syncFlag
);
  deserCtl_t ctl;
  logic      rawComma;

  deser_ctrl #(.CHAR_W(CHAR_W)) u_ctrl (
    .clk(clk), .rst(rst), .bitEn(bitEn), .frameEn(frameEn),
    .wideMode(wideMode), .rawComma(rawComma), .ctl(ctl), .wordStb(wordStb)
  );

  deser_datapath #(.CHAR_W(CHAR_W), .PAT_W(PAT_W), .COMMA_PAT(COMMA_PAT)) u_dp (
    .clk(clk), .rst(rst), .serIn(serIn), .wideMode(wideMode), .ctl(ctl),
    .rawComma(rawComma), .outBus(outBus), .syncFlag(syncFlag)
  );
endmodule

// File: rtl/deser_chk.sv
module deser_chk #(
  parameter int CHAR_W = 10,
  parameter int PAT_W = 7,
  parameter logic [PAT_W-1:0] COMMA_PAT = 7'b0011111
) (
  input logic                clk,
  input logic                rst,
  input logic                bitEn,
  input logic                wideMode,
  input logic                frameEn,
  input logic [2*CHAR_W-1:0] outBus,
  input logic                wordStb,
  input logic                syncFlag
);
  logic [7:0] gap;
  logic       haveStb, cleanGap, modeRef, prevMode;

  always_ff @(posedge clk) begin
    prevMode <= wideMode;
    if (rst) begin
      gap <= '0; haveStb <= 1'b0; cleanGap <= 1'b0; modeRef <= 1'b0;
    end else if (wordStb) begin
      haveStb  <= 1'b1;
      gap      <= bitEn ? 8'd1 : 8'd0;
      modeRef  <= wideMode;
      cleanGap <= !frameEn && (wideMode == prevMode);
    end else begin
      if (bitEn && gap != 8'hFF) gap <= gap + 8'd1;
      if (frameEn || wideMode != modeRef) cleanGap <= 1'b0;
    end
  end

  a_r8_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (outBus == '0 && !syncFlag && !wordStb));

  a_r9_stb_after_event: assert property (@(posedge clk) disable iff (rst)
    wordStb |-> $past(bitEn));

  a_r9_bus_holds: assert property (@(posedge clk) disable iff (rst)
    (!wordStb && !$past(rst)) |-> ($stable(outBus) && $stable(syncFlag)));

  a_r4_no_runt: assert property (@(posedge clk) disable iff (rst)
    (wordStb && haveStb) |-> (gap >= 8'(CHAR_W)));

  a_r5_unframed_period: assert property (@(posedge clk) disable iff (rst)
    (wordStb && haveStb && cleanGap) |-> (gap == (modeRef ? 8'(2*CHAR_W) : 8'(CHAR_W))));

  a_r6_low_ones: assert property (@(posedge clk) disable iff (rst)
    (wordStb && !$past(wideMode)) |-> (&outBus[CHAR_W-1:0]));

  a_r7_sync_has_comma: assert property (@(posedge clk) disable iff (rst)
    syncFlag |-> (outBus[2*CHAR_W-1 -: PAT_W] == COMMA_PAT || outBus[CHAR_W-1 -: PAT_W] == COMMA_PAT));
endmodule

bind comma_deser deser_chk #(.CHAR_W(CHAR_W), .PAT_W(PAT_W), .COMMA_PAT(COMMA_PAT)) u_chk (
  .clk(clk), .rst(rst), .bitEn(bitEn), .wideMode(wideMode), .frameEn(frameEn),
  .outBus(outBus), .wordStb(wordStb), .syncFlag(syncFlag)
);

// File: tb/sim_comma_deser.sv
module sim_comma_deser;
  logic clk = 1'b0, rst = 1'b1, bitEn = 1'b0, serIn = 1'b0;
  logic wideMode = 1'b0, frameEn = 1'b0;
  logic [19:0] outBus;
  logic wordStb, syncFlag;

  comma_deser u0 (
    .clk(clk), .rst(rst), .bitEn(bitEn), .serIn(serIn), .wideMode(wideMode),
    .frameEn(frameEn), .outBus(outBus), .wordStb(wordStb), .syncFlag(syncFlag)
  );

  always #4 clk = ~clk;

  int errs = 0, checks = 0;
  logic bits [0:8191];
  int ev, target, wLen, lastObs;
  logic [19:0] lastBus;
  bit done = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h (event %0d)", tag, act, exp, ev);
    end
  endtask

  function automatic logic isComma(input int endIdx);
    logic [6:0] p;
    for (int i = 0; i < 7; i++) p[6-i] = bits[endIdx-9+i];
    return p == 7'b0011111;
  endfunction

  task automatic doReset(input logic wide, input logic fe);
    @(negedge clk);
    rst = 1'b1; bitEn = 1'b0; wideMode = wide; frameEn = fe;
    @(negedge clk);
    check("R8 reset bus", 32'(outBus), 32'h0);
    check("R8 reset sync", 32'(syncFlag), 32'h0);
    check("R8 reset strobe", 32'(wordStb), 32'h0);
    rst = 1'b0;
    ev = 0; wLen = wide ? 20 : 10; target = wLen; lastObs = 0; lastBus = '0;
  endtask

  // called at a negedge; returns at a negedge
  task automatic stepBit(input logic b);
    logic expStb;
    logic [19:0] eb;
    logic es;
    bitEn = 1'b1; serIn = b;
    ev++; bits[ev] = b;
    expStb = 1'b0; eb = '1;
    if (ev == target) begin
      target += wLen;
      if (ev >= wLen + 10) expStb = 1'b1;
    end else if (frameEn && ev >= 10 && isComma(ev)) begin
      target = ev + wLen;
    end
    if (expStb) begin
      if (wLen == 10) for (int i = 0; i < 10; i++) eb[19-i] = bits[ev-19+i];
      else            for (int i = 0; i < 20; i++) eb[19-i] = bits[ev-29+i];
    end
    es = (eb[19:13] == 7'b0011111) || (wLen == 20 && eb[9:3] == 7'b0011111);
    @(posedge clk);
    @(negedge clk);
    bitEn = 1'b0;
    check(frameEn ? "R1 R2 strobe timing" : "R5 strobe timing", 32'(wordStb), 32'(expStb));
    if (expStb && wordStb) begin
      check(wLen == 20 ? "R3 upper char" : "R2 upper char", 32'(outBus[19:10]), 32'(eb[19:10]));
      check(wLen == 20 ? "R3 lower char" : "R6 lower ones", 32'(outBus[9:0]), 32'(eb[9:0]));
      check("R7 sync", 32'(syncFlag), 32'(es));
      if (lastObs > 0) check("R4 spacing", 32'(ev - lastObs >= wLen), 32'h1);
      lastObs = ev;
      lastBus = outBus;
    end else if (!wordStb) begin
      check("R9 bus held", 32'(outBus), 32'(lastBus));
    end
    if ($urandom % 4 == 0) begin
      @(negedge clk);
      check("R9 no strobe idle", 32'(wordStb), 32'h0);
    end
  endtask

  task automatic sendChar(input logic [9:0] c);
    for (int i = 9; i >= 0; i--) stepBit(c[i]);
  endtask

  task automatic runPhase(input logic wide, input logic fe, input int nChars);
    doReset(wide, fe);
    for (int n = 0; n < nChars; n++) begin
      int r = $urandom % 16;
      if (r < 3)       sendChar({7'b0011111, 3'($urandom)});
      else if (r == 3) sendChar({7'b1100000, 3'($urandom)});
      else if (r == 4) begin
        int k = 1 + $urandom % 9;
        for (int j = 0; j < k; j++) stepBit(1'($urandom));
      end else         sendChar(10'($urandom));
    end
  endtask

  task automatic directed(input logic wide);
    doReset(wide, 1'b1);
    for (int n = 0; n < 4; n++) sendChar(10'h2A5);
    sendChar(10'b0011111010);
    sendChar(10'b0011111010);
    stepBit(1'b1);                       // slip of one bit just past a boundary
    sendChar(10'b0011111001);
    sendChar(10'h155);
    for (int j = 0; j < 9; j++) stepBit(1'b1); // slip of nine bits
    sendChar(10'b0011111100);
    for (int n = 0; n < 3; n++) sendChar(10'b1100000101); // R1 inverted comma
    for (int n = 0; n < 4; n++) sendChar(10'h0F3);
  endtask

  initial begin
    void'($urandom(32'd4242));
    directed(1'b0);
    directed(1'b1);
    runPhase(1'b0, 1'b1, 300);
    runPhase(1'b1, 1'b1, 300);
    runPhase(1'b0, 1'b0, 200);
    runPhase(1'b1, 1'b0, 200);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #1400000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule